// File: doc/BRIEF.md
# BCD Hundredths Watchdog Timer

This block is a software watchdog whose timeout is held as four BCD digits in two byte-wide registers. One register carries the fractional part of the timeout, in hundredths and tenths of a second. The other carries whole seconds. The timeout can therefore be set anywhere from 00.01 s to 99.99 s. A 100 Hz tick strobe drives an internal BCD down-counter. When that counter reaches zero, a watchdog flag is raised and an active-low interrupt goes low.

Software keeps the watchdog quiet by touching either timeout register often enough. Any read or write to one of the two registers restarts the countdown from the stored timeout and clears the flag. If software stops touching the registers, the countdown expires, reloads itself on the next tick and keeps running. The flag stays raised until the next register access. A timeout of zero disables the watchdog.

The live count cannot be read. The registers always return the timeout that was written.

Top module: `hsec_wdt_top`

## Requirements
- R1: After reset, `wd_flag` is 0, `wd_irq_n` is 1, and both timeout registers read 0x00.
- R2: Address 0xC holds the fractional byte: hundredths in bits 3:0 and tenths in bits 7:4. Address 0xD holds the seconds byte: units in bits 3:0 and tens in bits 7:4. `reg_rdata` shows the stored byte of the addressed register in the same cycle as the address. Any other address reads 0x00.
- R3: A `reg_wr` or `reg_rd` strobe at address 0xC or 0xD loads the counter with the timeout as it stands after that cycle's write, and clears `wd_flag` at the next clock edge.
- R4: Each `tick_100hz` cycle decrements the counter by one in BCD, with the borrow carried across all four digits. With a timeout of N hundredths, `wd_flag` rises at the edge of the N-th tick after the last access; for example 01.00 expires on the 100th tick and 99.99 on the 9999th.
- R5: Once set, `wd_flag` stays set until an access to 0xC or 0xD. After reaching zero, the counter reloads the timeout on the next tick and counts down again.
- R6: `wd_irq_n` is always the inverse of `wd_flag`.
- R7: While both timeout bytes are 0x00, ticks have no effect and `wd_flag` stays 0.
- R8: When an access to 0xC or 0xD and a tick fall in the same cycle, the access takes effect and the tick is discarded.
- R9: Reads and writes to any address other than 0xC and 0xD leave the timeout registers, the counter and `wd_flag` unchanged.
- R10: The two registers may be written in either order. Each write restarts the countdown from the combined value present after that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_100hz | input | 1 | One-cycle strobe at 100 Hz |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| wd_flag | output | 1 | Watchdog expired flag, active high |
| wd_irq_n | output | 1 | Watchdog interrupt, active low |

## Verification
Two events can land on the same clock edge: a restart caused by a register access, and a countdown step caused by a tick. The bench provokes this in two situations. The first is a tick that would otherwise expire the counter; the second is a tick arriving after the flag is already set. In both it judges that the flag ends up clear and that the next expiry comes a full timeout later. Random traffic also mixes ticks, accesses and foreign addresses at fixed rates, so such collisions recur throughout the run, with a reference model deciding the expected flag in every cycle.

// File: rtl/hsec_wdt_pkg.sv
`timescale 1ns/1ps
package hsec_wdt_pkg;
  typedef logic [3:0] bcd_digit_t;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_FRAC = 2'd1,
    SEL_SECS = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/hsec_wdt_rst_sync.sv
`timescale 1ns/1ps
module hsec_wdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  assign sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/hsec_wdt_regs.sv
`timescale 1ns/1ps
module hsec_wdt_regs
  import hsec_wdt_pkg::*;
#(
  parameter int                 ADDR_W    = 4,
  parameter int                 DATA_W    = 8,
  parameter logic [ADDR_W-1:0]  FRAC_ADDR = 'hC,
  parameter logic [ADDR_W-1:0]  SECS_ADDR = 'hD
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  wr,
  input  logic                  rd,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata,
  output logic                  access,
  output logic [2*DATA_W-1:0]   reload_q,
  output logic [2*DATA_W-1:0]   reload_next
);
  reg_sel_e          sel;
  logic              frac_en, secs_en;
  logic [DATA_W-1:0] frac_q, frac_d;
  logic [DATA_W-1:0] secs_q, secs_d;

  // address decode
  always_comb begin
    if (addr == FRAC_ADDR)      sel = SEL_FRAC;
    else if (addr == SECS_ADDR) sel = SEL_SECS;
    else                        sel = SEL_NONE;
  end

  assign frac_en = wr && (sel == SEL_FRAC);
  assign secs_en = wr && (sel == SEL_SECS);
  assign access  = (wr || rd) && (sel != SEL_NONE);

  // next-state values
  always_comb begin
    frac_d = frac_q;
    secs_d = secs_q;
    if (frac_en) frac_d = wdata;
    if (secs_en) secs_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       frac_q <= '0;
    else if (frac_en) frac_q <= frac_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       secs_q <= '0;
    else if (secs_en) secs_q <= secs_d;
  end

  // read path always returns the stored timeout, never the live count
  always_comb begin
    unique case (sel)
      SEL_FRAC: rdata = frac_q;
      SEL_SECS: rdata = secs_q;
      default:  rdata = '0;
    endcase
  end

  assign reload_q    = {secs_q, frac_q};
  assign reload_next = {secs_d, frac_d};
endmodule

// File: rtl/hsec_wdt_bcd_dec.sv
`timescale 1ns/1ps
module hsec_wdt_bcd_dec
  import hsec_wdt_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int VAL_W = 4 * DIGITS
) (
  input  logic [VAL_W-1:0] value_in,
  output logic [VAL_W-1:0] value_out,
  output logic             is_zero,
  output logic             is_one
);
  logic [DIGITS:0] borrow;

  assign borrow[0] = 1'b1;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    bcd_digit_t d_in, d_out;
    logic       b_out;

    assign d_in = value_in[4*g +: 4];

    always_comb begin
      if (!borrow[g]) begin
        d_out = d_in;
        b_out = 1'b0;
      end else if (d_in == 4'd0) begin
        d_out = 4'd9;
        b_out = 1'b1;
      end else begin
        d_out = d_in - 4'd1;
        b_out = 1'b0;
      end
    end

    assign borrow[g+1]          = b_out;
    assign value_out[4*g +: 4]  = d_out;
  end

  // a borrow out of the top digit means every digit was zero
  assign is_zero = borrow[DIGITS];
  assign is_one  = !borrow[DIGITS] && (value_out == '0);
endmodule

// File: rtl/hsec_wdt_count.sv
`timescale 1ns/1ps
module hsec_wdt_count #(
  parameter int DIGITS = 4,
  localparam int CNT_W = 4 * DIGITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             access,
  input  logic [CNT_W-1:0] reload_q,
  input  logic [CNT_W-1:0] reload_next,
  output logic             flag
);
  logic [CNT_W-1:0] count_q, count_d, dec_val;
  logic             count_en;
  logic             flag_q, flag_d, flag_en;
  logic             cnt_zero, cnt_one, enabled;

  hsec_wdt_bcd_dec #(.DIGITS(DIGITS)) u_dec (
    .value_in  (count_q),
    .value_out (dec_val),
    .is_zero   (cnt_zero),
    .is_one    (cnt_one)
  );

  assign enabled = (reload_q != '0);

  always_comb begin
    count_d  = count_q;
    count_en = 1'b0;
    flag_d   = flag_q;
    flag_en  = 1'b0;
    if (access) begin
      // restart has priority over a tick in the same cycle
      count_en = 1'b1;
      count_d  = reload_next;
      flag_en  = 1'b1;
      flag_d   = 1'b0;
    end else if (tick && enabled) begin
      count_en = 1'b1;
      if (cnt_zero) begin
        count_d = reload_q;
      end else begin
        count_d = dec_val;
        if (cnt_one) begin
          flag_en = 1'b1;
          flag_d  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/hsec_wdt_top.sv
`timescale 1ns/1ps
module hsec_wdt_top #(
  parameter int                ADDR_W      = 4,
  parameter int                DATA_W      = 8,
  parameter logic [ADDR_W-1:0] FRAC_ADDR   = 'hC,
  parameter logic [ADDR_W-1:0] SECS_ADDR   = 'hD,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_100hz,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              wd_flag,
  output logic              wd_irq_n
);
  localparam int RELOAD_W = 2 * DATA_W;
  localparam int DIGITS   = RELOAD_W / 4;

  logic                rst_sync_n;
  logic                access;
  logic [RELOAD_W-1:0] reload_q;
  logic [RELOAD_W-1:0] reload_next;
  logic                flag;

  hsec_wdt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  hsec_wdt_regs #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .FRAC_ADDR (FRAC_ADDR),
    .SECS_ADDR (SECS_ADDR)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .addr        (reg_addr),
    .wr          (reg_wr),
    .rd          (reg_rd),
    .wdata       (reg_wdata),
    .rdata       (reg_rdata),
    .access      (access),
    .reload_q    (reload_q),
    .reload_next (reload_next)
  );

  hsec_wdt_count #(.DIGITS(DIGITS)) u_count (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .tick        (tick_100hz),
    .access      (access),
    .reload_q    (reload_q),
    .reload_next (reload_next),
    .flag        (flag)
  );

  assign wd_flag  = flag;
  assign wd_irq_n = ~flag;
endmodule

// File: rtl/hsec_wdt_chk.sv
`timescale 1ns/1ps
module hsec_wdt_chk #(
  parameter int                ADDR_W    = 4,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] FRAC_ADDR = 'hC,
  parameter logic [ADDR_W-1:0] SECS_ADDR = 'hD
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick,
  input logic [ADDR_W-1:0]   addr,
  input logic                wr,
  input logic                rd,
  input logic                flag,
  input logic                irq_n,
  input logic [2*DATA_W-1:0] reload_q
);
  logic hit, wr_hit;
  assign hit    = (wr || rd) && (addr == FRAC_ADDR || addr == SECS_ADDR);
  assign wr_hit = wr && (addr == FRAC_ADDR || addr == SECS_ADDR);

  assert_access_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !flag);

  // collision of tick and access: access wins (R8)
  assert_access_beats_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && tick) |=> !flag);

  assert_rise_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(tick));

  assert_flag_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !hit) |=> flag);

  assert_irq_polarity_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n != flag);

  assert_zero_disables_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_q == '0 && !flag && !hit) |=> !flag);

  assert_regs_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(reload_q));
endmodule

bind hsec_wdt_top hsec_wdt_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .FRAC_ADDR (FRAC_ADDR),
  .SECS_ADDR (SECS_ADDR)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick_100hz),
  .addr     (reg_addr),
  .wr       (reg_wr),
  .rd       (reg_rd),
  .flag     (wd_flag),
  .irq_n    (wd_irq_n),
  .reload_q (reload_q)
);

// File: tb/hsec_wdt_top_tb_top.sv
`timescale 1ns/1ps
module hsec_wdt_top_tb_top;
  localparam logic [3:0] A_FRAC = 4'hC;
  localparam logic [3:0] A_SECS = 4'hD;

  logic       clk;
  logic       rst_n;
  logic       tick_100hz;
  logic [3:0] reg_addr;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;
  logic       wd_flag, wd_irq_n;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_frac, m_secs;
  int         m_cnt;
  bit         m_flag;

  hsec_wdt_top dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_100hz (tick_100hz),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .wd_flag    (wd_flag),
    .wd_irq_n   (wd_irq_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int byte_val(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] to_bcd(input int n);
    logic [7:0] r;
    r[7:4] = 4'((n / 10) % 10);
    r[3:0] = 4'(n % 10);
    return r;
  endfunction

  function automatic int reload_of(input logic [7:0] s, input logic [7:0] f);
    return byte_val(s) * 100 + byte_val(f);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, update model at the edge, compare at next negedge
  task automatic step(input logic [3:0] a, input bit w, input bit r,
                      input logic [7:0] d, input bit t, input string req);
    logic [7:0] exp_rd;
    bit         acc;
    int         val;
    reg_addr = a; reg_wr = w; reg_rd = r; reg_wdata = d; tick_100hz = t;
    #1;
    exp_rd = (a == A_FRAC) ? m_frac : (a == A_SECS) ? m_secs : 8'h00;
    if (r) chk(reg_rdata == exp_rd, "R2 read", int'(reg_rdata), int'(exp_rd));
    acc = (w || r) && (a == A_FRAC || a == A_SECS);
    if (w && a == A_FRAC) m_frac = d;
    if (w && a == A_SECS) m_secs = d;
    val = reload_of(m_secs, m_frac);
    if (acc) begin
      m_cnt  = val;
      m_flag = 1'b0;
    end else if (t && val != 0) begin
      if (m_cnt == 0) m_cnt = val;
      else begin
        m_cnt--;
        if (m_cnt == 0) m_flag = 1'b1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0; tick_100hz = 1'b0;
    chk(wd_flag == m_flag, req, int'(wd_flag), int'(m_flag));
    chk(wd_irq_n == !m_flag, "R6 irq polarity", int'(wd_irq_n), int'(!m_flag));
  endtask

  task automatic ticks(input int n, input string req);
    for (int i = 0; i < n; i++) step(4'h0, 1'b0, 1'b0, 8'h00, 1'b1, req);
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d, input string req);
    step(a, 1'b1, 1'b0, d, 1'b0, req);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog timeout actual=0 expected=1");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; tick_100hz = 1'b0; reg_addr = 4'h0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = 8'h00;
    m_frac = 8'h00; m_secs = 8'h00; m_cnt = 0; m_flag = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state, read without strobe
    chk(wd_flag == 1'b0, "R1 flag", int'(wd_flag), 0);
    chk(wd_irq_n == 1'b1, "R1 irq_n", int'(wd_irq_n), 1);
    reg_addr = A_FRAC; #1;
    chk(reg_rdata == 8'h00, "R1 frac reg", int'(reg_rdata), 0);
    reg_addr = A_SECS; #1;
    chk(reg_rdata == 8'h00, "R1 secs reg", int'(reg_rdata), 0);
    @(negedge clk);

    // R7: zero timeout, ticks do nothing
    ticks(50, "R7 disabled");
    chk(wd_flag == 1'b0, "R7 still clear", int'(wd_flag), 0);

    // R2 / R4 basic expiry of 00.05
    wr_reg(A_FRAC, 8'h05, "R2 write frac");
    wr_reg(A_SECS, 8'h00, "R2 write secs");
    step(A_FRAC, 1'b0, 1'b1, 8'h00, 1'b0, "R2 readback");
    step(A_SECS, 1'b0, 1'b1, 8'h00, 1'b0, "R2 readback");
    ticks(4, "R4 before expiry");
    chk(wd_flag == 1'b0, "R4 not yet at 4 ticks", int'(wd_flag), 0);
    ticks(1, "R4 expiry");
    chk(wd_flag == 1'b1, "R4 expired at 5 ticks", int'(wd_flag), 1);

    // R5 flag sticky while the countdown wraps
    ticks(23, "R5 sticky");
    chk(wd_flag == 1'b1, "R5 still set", int'(wd_flag), 1);

    // R9 foreign addresses leave everything alone
    wr_reg(4'h3, 8'h42, "R9 foreign write");
    step(4'hE, 1'b0, 1'b1, 8'h00, 1'b1, "R9 foreign read");
    chk(wd_flag == 1'b1, "R9 flag kept", int'(wd_flag), 1);
    reg_addr = A_FRAC; #1;
    chk(reg_rdata == 8'h05, "R9 frac unchanged", int'(reg_rdata), 5);
    @(negedge clk);

    // R3 read clears
    step(A_SECS, 1'b0, 1'b1, 8'h00, 1'b0, "R3 read clears");
    chk(wd_flag == 1'b0, "R3 cleared", int'(wd_flag), 0);

    // R8 collision: tick that would expire plus access
    ticks(4, "R8 lead-in");
    step(A_FRAC, 1'b0, 1'b1, 8'h00, 1'b1, "R8 collision");
    chk(wd_flag == 1'b0, "R8 access wins", int'(wd_flag), 0);
    ticks(4, "R8 restart");
    chk(wd_flag == 1'b0, "R8 full period again", int'(wd_flag), 0);
    ticks(1, "R8 expiry");
    chk(wd_flag == 1'b1, "R8 expiry after full timeout", int'(wd_flag), 1);
    step(A_SECS, 1'b1, 1'b0, 8'h00, 1'b1, "R8 collision flag set");
    chk(wd_flag == 1'b0, "R8 set flag cleared", int'(wd_flag), 0);

    // R10 secs then frac, BCD borrow 01.00 -> 100 ticks (R4)
    wr_reg(A_SECS, 8'h01, "R10 secs first");
    wr_reg(A_FRAC, 8'h00, "R10 frac second");
    ticks(99, "R4 borrow");
    chk(wd_flag == 1'b0, "R4 borrow not at 99", int'(wd_flag), 0);
    ticks(1, "R4 borrow expiry");
    chk(wd_flag == 1'b1, "R4 expired at 100", int'(wd_flag), 1);

    // R10 frac write restarts from 01.03, then secs write to 00.03
    wr_reg(A_FRAC, 8'h03, "R10 frac first");
    wr_reg(A_SECS, 8'h00, "R10 secs second");
    ticks(3, "R10 combined value");
    chk(wd_flag == 1'b1, "R10 expiry at 3", int'(wd_flag), 1);

    // R4 maximum 99.99
    wr_reg(A_FRAC, 8'h99, "R4 max frac");
    wr_reg(A_SECS, 8'h99, "R4 max secs");
    ticks(9998, "R4 max countdown");
    chk(wd_flag == 1'b0, "R4 max not at 9998", int'(wd_flag), 0);
    ticks(1, "R4 max expiry");
    chk(wd_flag == 1'b1, "R4 max expired at 9999", int'(wd_flag), 1);

    // R7 disable via zero writes
    wr_reg(A_FRAC, 8'h00, "R7 zero frac");
    wr_reg(A_SECS, 8'h00, "R7 zero secs");
    ticks(300, "R7 zero timeout");
    chk(wd_flag == 1'b0, "R7 stays clear", int'(wd_flag), 0);

    // random mix, model judged every cycle (R3 R4 R5 R8 R9)
    for (int i = 0; i < 5000; i++) begin
      int         sel;
      bit         t;
      logic [7:0] d;
      sel = int'($urandom_range(0, 99));
      t   = ($urandom_range(0, 1) == 1);
      if (sel < 2) begin
        d = to_bcd(int'($urandom_range(1, 20)));
        step(A_FRAC, 1'b1, 1'b0, d, t, "R3 random frac write");
      end else if (sel < 3) begin
        d = to_bcd(int'($urandom_range(0, 1)));
        step(A_SECS, 1'b1, 1'b0, d, t, "R3 random secs write");
      end else if (sel < 5) begin
        step(($urandom_range(0, 1) == 1) ? A_FRAC : A_SECS, 1'b0, 1'b1, 8'h00, t,
             "R3 random read");
      end else if (sel < 8) begin
        step(4'(int'($urandom_range(0, 11))), 1'b1, 1'b1,
             8'($urandom_range(0, 255)), t, "R9 random foreign");
      end else begin
        step(4'h0, 1'b0, 1'b0, 8'h00, t, "R5 random idle");
      end
    end

    finish_run();
  end
endmodule